// File: doc/BRIEF.md
# Input-Transition Pattern Detector

This block watches a pair of level inputs, `x1` and `x2`, and raises its output `z` while the pair reads 11, but only when the distinct combination seen just before that 11 was 01. It does not look at a serial bit stream. It remembers the order in which input combinations were entered. Each combination counts once however long it is held, so a pair that stays put never erases the memory of where it came from.

The inputs are sampled on the clock. They may first pass through a parameterised chain of sampling registers, which can serve as a synchroniser for levels that come from another clock domain. Two registers then track the current combination and the previous distinct one. A parameter option adds a register on the output. After reset the block behaves as if the inputs had rested at 00.

Top module: `trans_det_top`

## Requirements
- R1: The input pair is formed as {x1, x2}, with x1 as bit 1 and x2 as bit 0. It passes through SAMPLE_STAGES sampling registers before the tracking logic sees it.
- R2: The remembered previous combination takes the old current combination only when the sampled pair differs from the current one. Holding any combination for any number of cycles leaves both unchanged.
- R3: While rst_n is low, the current and previous combinations are 00 and z is 0.
- R4: z is 1 exactly when the current combination is 11 and the previous distinct combination is 01.
- R5: When 11 is entered from 10, z stays 0 for the whole time the inputs remain at 11.
- R6: When 11 is entered straight from 00 (both bits rise together), z stays 0 for the whole dwell at 11.
- R7: Once raised, z stays 1 for every cycle the inputs hold 11, whatever the length of the hold.
- R8: A change at the inputs reaches z exactly SAMPLE_STAGES + 1 + OUT_REG clock edges later.
- R9: Leaving 11 drops z. Entering 11 again from 01 raises it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x1 | input | 1 | First level input, bit 1 of the pair |
| x2 | input | 1 | Second level input, bit 0 of the pair |
| z | output | 1 | High while 11 is held after being entered from 01 |

## Verification
The bench builds two copies of the block side by side. One uses the defaults, SAMPLE_STAGES=2 and OUT_REG=1, which gives a four-edge path with both generate variants present. The other uses SAMPLE_STAGES=0 and OUT_REG=0, where the sampler is bypassed and z is combinational from the tracking registers. Comparing both against the same model pins down the latency of each variant exactly. It also exercises both branches of each generate choice, and long holds, double-bit jumps and a reset in the middle of a fired dwell all fall within reach.

// File: rtl/trans_det_pkg.sv
package trans_det_pkg;

   // Pair encoding: bit 1 = x1, bit 0 = x2.
   typedef logic [1:0] pair_t;

   localparam pair_t PAIR_REST = 2'b00;
   localparam pair_t PAIR_ARM  = 2'b01;
   localparam pair_t PAIR_FIRE = 2'b11;

   function automatic logic pair_hit(input pair_t cur, input pair_t prev);
      return (cur == PAIR_FIRE) && (prev == PAIR_ARM);
   endfunction

endpackage

// File: rtl/trans_det_sampler.sv
module trans_det_sampler
   import trans_det_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  pair_t pair_i,
   output pair_t pair_o
);

   pair_t stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= PAIR_REST;
      end else begin
         stage_q[0] <= pair_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign pair_o = stage_q[STAGES-1];

endmodule

// File: rtl/trans_det_history.sv
module trans_det_history
   import trans_det_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  pair_t pair_i,
   output pair_t cur_o,
   output pair_t prev_o
);

   pair_t cur_q, prev_q;
   logic  moved;

   assign moved = (pair_i != cur_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= PAIR_REST;
         prev_q <= PAIR_REST;
      end else if (moved) begin
         prev_q <= cur_q;
         cur_q  <= pair_i;
      end
   end

   assign cur_o  = cur_q;
   assign prev_o = prev_q;

endmodule

// File: rtl/trans_det_decide.sv
module trans_det_decide
   import trans_det_pkg::*;
(
   input  pair_t cur_i,
   input  pair_t prev_i,
   output logic  hit_o
);

   assign hit_o = pair_hit(cur_i, prev_i);

endmodule

// File: rtl/trans_det_top.sv
module trans_det_top
   import trans_det_pkg::*;
#(
   parameter int SAMPLE_STAGES = 2,
   parameter bit OUT_REG       = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic x1,
   input  logic x2,
   output logic z
);

   localparam int MAX_STAGES = 8;

   if (SAMPLE_STAGES < 0 || SAMPLE_STAGES > MAX_STAGES) begin : g_bad_stages
      $error("trans_det_top: SAMPLE_STAGES out of range");
   end

   pair_t raw_pair, seen_pair, cur_pair, prev_pair;
   logic  hit;

   assign raw_pair = {x1, x2};

   if (SAMPLE_STAGES > 0) begin : g_sample
      trans_det_sampler #(.STAGES(SAMPLE_STAGES)) u_sampler (
         .clk    (clk),
         .rst_n  (rst_n),
         .pair_i (raw_pair),
         .pair_o (seen_pair)
      );
   end else begin : g_direct
      assign seen_pair = raw_pair;
   end

   trans_det_history u_history (
      .clk    (clk),
      .rst_n  (rst_n),
      .pair_i (seen_pair),
      .cur_o  (cur_pair),
      .prev_o (prev_pair)
   );

   trans_det_decide u_decide (
      .cur_i  (cur_pair),
      .prev_i (prev_pair),
      .hit_o  (hit)
   );

   if (OUT_REG) begin : g_out_reg
      logic z_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) z_q <= 1'b0;
         else        z_q <= hit;
      end
      assign z = z_q;
   end else begin : g_out_comb
      assign z = hit;
   end

endmodule

// File: rtl/trans_det_chk.sv
module trans_det_chk
   import trans_det_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input logic  clk,
   input logic  rst_n,
   input pair_t cur,
   input pair_t prev,
   input logic  z
);

   // R3: output held low while in reset
   assert_reset_quiet_R3: assert property (@(posedge clk) !rst_n |-> !z);

   // R2: once the two tracked combinations differ, they never become equal again
   assert_hist_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prev != cur) |=> (prev != cur));

   // R2: previous only moves together with current, taking its old value
   assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur) |-> (prev == $past(cur)));

   assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cur) |-> $stable(prev));

   if (OUT_REG) begin : g_reg_chk
      // R4: registered output reflects the previous cycle's tracked state
      assert_fire_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
         z |-> ($past(cur) == PAIR_FIRE && $past(prev) == PAIR_ARM));
   end else begin : g_comb_chk
      // R4: output reflects the current tracked state
      assert_fire_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
         z |-> (cur == PAIR_FIRE && prev == PAIR_ARM));
   end

endmodule

bind trans_det_top trans_det_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cur   (cur_pair),
   .prev  (prev_pair),
   .z     (z)
);

// File: tb/trans_det_top_tb.sv
`timescale 1ns/1ps
module trans_det_top_tb;

   localparam int LAT_FULL = 2 + 1 + 1;   // defaults: R8 latency
   localparam int LAT_MIN  = 0 + 1 + 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic x1 = 1'b0, x2 = 1'b0;
   logic z_full, z_min;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [1:0] m_cur = 2'b00, m_prev = 2'b00;
   logic [7:0] hist = 8'h00;

   always #2 clk = ~clk;   // 250 MHz

   trans_det_top u_dut (
      .clk(clk), .rst_n(rst_n), .x1(x1), .x2(x2), .z(z_full));

   trans_det_top #(.SAMPLE_STAGES(0), .OUT_REG(1'b0)) u_dut_min (
      .clk(clk), .rst_n(rst_n), .x1(x1), .x2(x2), .z(z_min));

   function automatic logic model_z(input logic [1:0] cur, input logic [1:0] prev);
      return (cur == 2'b11) && (prev == 2'b01);
   endfunction

   task automatic check(input string tag, input string which, input logic got, input logic exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s got=%0b exp=%0b at %0t", tag, which, got, exp, $time);
      end
   endtask

   // Apply a pair at a negedge, clock it in, update the model, check at the next negedge.
   task automatic step(input logic [1:0] pair, input string tag);
      {x1, x2} = pair;
      @(posedge clk);
      if (pair != m_cur) begin
         m_prev = m_cur;
         m_cur  = pair;
      end
      hist = {hist[6:0], model_z(m_cur, m_prev)};
      @(negedge clk);
      check(tag, "full", z_full, hist[LAT_FULL-1]);
      check(tag, "min",  z_min,  hist[LAT_MIN-1]);
   endtask

   task automatic hold(input logic [1:0] pair, input int n, input string tag);
      for (int i = 0; i < n; i++) step(pair, tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      {x1, x2} = 2'b00;
      m_cur = 2'b00; m_prev = 2'b00; hist = 8'h00;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R3", "full", z_full, 1'b0);
         check("R3", "min",  z_min,  1'b0);
      end
      rst_n = 1'b1;
   endtask

   initial begin
      int r;
      logic [1:0] p;
      void'($urandom(32'd2718));
      @(negedge clk);
      do_reset();
      hold(2'b00, 4, "R3");
      // R1 R4 R7 R8: 00 -> 01 -> 11 held
      hold(2'b01, 3, "R1");
      hold(2'b11, 8, "R7");
      // R9: leave and re-enter from 01
      hold(2'b01, 2, "R9");
      hold(2'b11, 5, "R9");
      // R5: 11 -> 10 -> 11 must stay low
      hold(2'b10, 3, "R5");
      hold(2'b11, 7, "R5");
      // R6: double-bit jump 00 -> 11
      hold(2'b00, 3, "R6");
      hold(2'b11, 6, "R6");
      // R2: long hold of 01 keeps the memory, then 11 fires
      hold(2'b01, 12, "R2");
      hold(2'b11, 4, "R2");
      // R8: single-cycle visit to 11 from 01
      hold(2'b01, 1, "R8");
      hold(2'b11, 1, "R8");
      hold(2'b01, 6, "R8");
      // R3: reset in the middle of a fired dwell, then 11 entered from rest
      hold(2'b11, 5, "R4");
      do_reset();
      hold(2'b11, 6, "R3");
      hold(2'b01, 2, "R4");
      hold(2'b11, 4, "R4");
      // Random walk, mostly one-bit flips
      p = {x1, x2};
      for (int i = 0; i < 3000; i++) begin
         r = int'($urandom % 8);
         case (r)
            4: p[1] = ~p[1];
            5, 6: p[0] = ~p[0];
            7: p = ~p;
            default: ;
         endcase
         step(p, "R4");
      end
      hold(2'b00, 6, "R4");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired got=hung exp=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule